// File: doc/BRIEF.md
# Four-Level Virtual Address Walker

This block turns a 64-bit virtual address into a 40-bit physical address by reading one table entry at each of four table levels held in memory. The caller presents an address together with the kind of access (write, user mode, instruction fetch) and the frame number of the top-level table. The walker splits the address into four 9-bit indices and a 12-bit byte offset. It reads one 8-byte entry per level through a single-outstanding memory read port, and then answers with either the physical address or a fault cause.

Each entry contributes three things. Its present bit can stop the walk. Its reserved field must be clear. Its writable, user and execute-disable bits are combined across the levels. The response carries the writable and user permissions that are in force for the page. A request whose upper address bits do not copy bit 47 is refused before any memory traffic takes place.

The controller has four states. `ST_IDLE` accepts a request, then goes to `ST_ISSUE` if the address is canonical and to `ST_DONE` if it is not. `ST_ISSUE` drives the entry read address and moves to `ST_WAIT` when memory takes it. `ST_WAIT` holds for the entry. It goes back to `ST_ISSUE` for the next lower level, or to `ST_DONE` on a fault or after the last level. `ST_DONE` holds the response until the caller takes it and then returns to `ST_IDLE`.

Top module: `va_walker`

## Requirements
- R1: A request whose address bits 63:48 are not all equal to bit 47 completes with cause 1 (non-canonical) and issues no memory read.
- R2: A full walk makes exactly four reads, in this order: top level using address bits 47:39, then bits 38:30, then bits 29:21, then bits 20:12. Each read address is the table base (frame number shifted left 12) plus the index times 8. The first base comes from `root_base`, and each later base comes from entry bits 39:12 of the previous read.
- R3: A walk with no fault returns cause 0 and a physical address built from bits 39:12 of the last entry and address bits 11:0.
- R4: An entry with bit 0 (present) clear ends the walk at once with cause 2, and no further reads are made.
- R5: A present entry with any of bits 51:40 set ends the walk with cause 3.
- R6: The reported writable flag is the AND of entry bit 1 across all four levels, and the reported user flag is the AND of entry bit 2. A write request without writable, or a user request without user, ends with cause 4.
- R7: When `nx_enable` is 1, a fetch request whose walk has bit 63 set in any entry ends with cause 5. When `nx_enable` is 0, or the request is not a fetch, bit 63 has no effect.
- R8: Not-present takes priority over reserved within the same entry. At the last level, execute-disable (5) takes priority over protection (4).
- R9: `req_ready` is high only when the walker is idle. A response stays valid and unchanged until `rsp_ready` is seen, and no request is accepted while a response is pending.
- R10: A memory read request holds its valid and address until `mem_req_ready`, and only one read is outstanding at a time.
- R11: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0.
- R12: On any fault, `rsp_paddr`, `rsp_writable` and `rsp_user` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| root_base | input | 28 | Frame number (physical bits 39:12) of the top-level table |
| nx_enable | input | 1 | Enables execute-disable checking |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Translation response valid |
| rsp_ready | input | 1 | Caller takes the response |
| rsp_paddr | output | 40 | Physical address, zero on fault |
| rsp_cause | output | 3 | 0 none, 1 non-canonical, 2 not present, 3 reserved, 4 protection, 5 execute-disable |
| rsp_writable | output | 1 | Combined write permission |
| rsp_user | output | 1 | Combined user permission |

## Verification
Two checks can resolve on the same returned entry. One pair is an entry that is both not present and carries reserved bits. The other pair is a leaf entry where execute-disable and a missing write permission both apply to a write-plus-fetch request. The bench builds both entries in its table and issues requests that reach them. It judges the outcome by the reported cause, which must be 2 and 5 respectively, and by the number of reads observed before the response.

// File: rtl/va_walk_pkg.sv
package va_walk_pkg;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_NONCANON = 3'd1,
        FLT_NOTPRES  = 3'd2,
        FLT_RSVD     = 3'd3,
        FLT_PROT     = 3'd4,
        FLT_XD       = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_state_e;

endpackage

// File: rtl/va_canon_split.sv
module va_canon_split #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12
) (
    input  logic [63:0]                   vaddr,
    output logic                          canonical,
    output logic [LEVELS-1:0][IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]              offset
);
    localparam int IMPL_W = OFF_W + LEVELS * IDX_W;
    localparam int EXT_W  = 64 - IMPL_W + 1;

    logic [EXT_W-1:0] ext_bits;

    assign ext_bits  = vaddr[63:IMPL_W-1];
    assign canonical = (&ext_bits) | ~(|ext_bits);
    assign offset    = vaddr[OFF_W-1:0];

    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_idx
            assign idx[g] = vaddr[OFF_W + g*IDX_W +: IDX_W];
        end
    endgenerate

endmodule

// File: rtl/va_entry_decode.sv
module va_entry_decode #(
    parameter int PA_W   = 40,
    parameter int OFF_W  = 12,
    parameter int RSV_HI = 51
) (
    input  logic [63:0]             entry,
    output logic                    present,
    output logic                    writable,
    output logic                    user,
    output logic                    exec_dis,
    output logic                    rsvd_bad,
    output logic [PA_W-OFF_W-1:0]   next_base
);
    localparam int XD_BIT = 63;

    assign present   = entry[0];
    assign writable  = entry[1];
    assign user      = entry[2];
    assign exec_dis  = entry[XD_BIT];
    assign rsvd_bad  = |entry[RSV_HI:PA_W];
    assign next_base = entry[PA_W-1:OFF_W];

endmodule

// File: rtl/va_fault_pick.sv
module va_fault_pick
    import va_walk_pkg::*;
(
    input  logic   present,
    input  logic   rsvd_bad,
    input  logic   last_level,
    input  logic   w_all,
    input  logic   u_all,
    input  logic   x_all,
    input  logic   nx_on,
    input  logic   want_w,
    input  logic   want_u,
    input  logic   want_x,
    output fault_e cause
);
    always_comb begin
        cause = FLT_NONE;
        if (!present)
            cause = FLT_NOTPRES;
        else if (rsvd_bad)
            cause = FLT_RSVD;
        else if (last_level) begin
            if (want_x && nx_on && x_all)
                cause = FLT_XD;
            else if ((want_w && !w_all) || (want_u && !u_all))
                cause = FLT_PROT;
        end
    end

endmodule

// File: rtl/va_walker.sv
module va_walker
    import va_walk_pkg::*;
#(
    parameter int PA_W   = 40,
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int RSV_HI = 51
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [63:0]            req_vaddr,
    input  logic                   req_write,
    input  logic                   req_user,
    input  logic                   req_fetch,
    input  logic [PA_W-OFF_W-1:0]  root_base,
    input  logic                   nx_enable,
    output logic                   mem_req_valid,
    input  logic                   mem_req_ready,
    output logic [63:0]            mem_req_addr,
    input  logic                   mem_rsp_valid,
    input  logic [63:0]            mem_rsp_data,
    output logic                   rsp_valid,
    input  logic                   rsp_ready,
    output logic [PA_W-1:0]        rsp_paddr,
    output logic [2:0]             rsp_cause,
    output logic                   rsp_writable,
    output logic                   rsp_user
);
    localparam int BASE_W  = PA_W - OFF_W;
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int ENT_SH  = 3;

    walk_state_e state_q, state_d;

    logic [63:0]       va_q;
    logic              want_w_q, want_u_q, want_x_q, nx_q;
    logic [BASE_W-1:0] base_q;
    logic [LVL_W-1:0]  lvl_q;
    logic              w_acc_q, u_acc_q, x_acc_q;
    fault_e            cause_q;
    logic [PA_W-1:0]   paddr_q;
    logic              rw_q, ru_q;

    logic [63:0]                  split_va;
    logic                         va_canon;
    logic [LEVELS-1:0][IDX_W-1:0] va_idx;
    logic [OFF_W-1:0]             va_off;

    logic              e_present, e_w, e_u, e_xd, e_rsvd;
    logic [BASE_W-1:0] e_base;
    logic              last_lvl;
    logic              w_all, u_all, x_all;
    fault_e            pick;
    logic [PA_W-1:0]   entry_addr;

    assign split_va = (state_q == ST_IDLE) ? req_vaddr : va_q;

    va_canon_split #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W)
    ) u_split (
        .vaddr     (split_va),
        .canonical (va_canon),
        .idx       (va_idx),
        .offset    (va_off)
    );

    va_entry_decode #(
        .PA_W   (PA_W),
        .OFF_W  (OFF_W),
        .RSV_HI (RSV_HI)
    ) u_decode (
        .entry     (mem_rsp_data),
        .present   (e_present),
        .writable  (e_w),
        .user      (e_u),
        .exec_dis  (e_xd),
        .rsvd_bad  (e_rsvd),
        .next_base (e_base)
    );

    assign last_lvl = (lvl_q == '0);
    assign w_all    = w_acc_q & e_w;
    assign u_all    = u_acc_q & e_u;
    assign x_all    = x_acc_q | e_xd;

    va_fault_pick u_pick (
        .present    (e_present),
        .rsvd_bad   (e_rsvd),
        .last_level (last_lvl),
        .w_all      (w_all),
        .u_all      (u_all),
        .x_all      (x_all),
        .nx_on      (nx_q),
        .want_w     (want_w_q),
        .want_u     (want_u_q),
        .want_x     (want_x_q),
        .cause      (pick)
    );

    assign entry_addr = {base_q, {OFF_W{1'b0}}}
                      + PA_W'({va_idx[lvl_q], {ENT_SH{1'b0}}});

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = va_canon ? ST_ISSUE : ST_DONE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid)
                          state_d = (pick != FLT_NONE || last_lvl) ? ST_DONE : ST_ISSUE;
            ST_DONE:  if (rsp_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q     <= '0;
            want_w_q <= 1'b0;
            want_u_q <= 1'b0;
            want_x_q <= 1'b0;
            nx_q     <= 1'b0;
            base_q   <= '0;
            lvl_q    <= '0;
            w_acc_q  <= 1'b1;
            u_acc_q  <= 1'b1;
            x_acc_q  <= 1'b0;
            cause_q  <= FLT_NONE;
            paddr_q  <= '0;
            rw_q     <= 1'b0;
            ru_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    va_q     <= req_vaddr;
                    want_w_q <= req_write;
                    want_u_q <= req_user;
                    want_x_q <= req_fetch;
                    nx_q     <= nx_enable;
                    base_q   <= root_base;
                    lvl_q    <= LVL_W'(LEVELS - 1);
                    w_acc_q  <= 1'b1;
                    u_acc_q  <= 1'b1;
                    x_acc_q  <= 1'b0;
                    cause_q  <= va_canon ? FLT_NONE : FLT_NONCANON;
                    paddr_q  <= '0;
                    rw_q     <= 1'b0;
                    ru_q     <= 1'b0;
                end
                ST_WAIT: if (mem_rsp_valid) begin
                    w_acc_q <= w_all;
                    u_acc_q <= u_all;
                    x_acc_q <= x_all;
                    base_q  <= e_base;
                    lvl_q   <= lvl_q - 1'b1;
                    if (pick != FLT_NONE) begin
                        cause_q <= pick;
                    end else if (last_lvl) begin
                        paddr_q <= {e_base, va_off};
                        rw_q    <= w_all;
                        ru_q    <= u_all;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = 64'(entry_addr);
        rsp_valid     = (state_q == ST_DONE);
        rsp_paddr     = paddr_q;
        rsp_cause     = cause_q;
        rsp_writable  = rw_q;
        rsp_user      = ru_q;
    end

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_cause)
                                    && $stable(rsp_paddr) && $stable(rsp_writable));

    a_r9_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req_valid) |-> !req_ready);

    a_r1_noncanon_direct: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_vaddr[63:47] != '0) && (req_vaddr[63:47] != '1)
        |=> rsp_valid && rsp_cause == 3'd1);

    a_r12_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_cause != 3'd0 |-> rsp_paddr == '0 && !rsp_writable && !rsp_user);

    a_r4_stop_on_absent: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WAIT && mem_rsp_valid && !mem_rsp_data[0]
        |=> rsp_valid && rsp_cause == 3'd2);

endmodule

// File: tb/va_walker_bench.sv
module va_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic        req_write = 1'b0, req_user = 1'b0, req_fetch = 1'b0;
    logic [27:0] root_base = 28'h1;
    logic        nx_enable = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [39:0] rsp_paddr;
    logic [2:0]  rsp_cause;
    logic        rsp_writable, rsp_user;

    always #2 clk = ~clk;

    va_walker u_va_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
        .root_base(root_base), .nx_enable(nx_enable),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause),
        .rsp_writable(rsp_writable), .rsp_user(rsp_user)
    );

    logic [63:0] pmem [longint unsigned];
    logic [63:0] rd_log [0:7];
    int          nreads = 0;
    int          stall_cnt = 0;
    int          nvec = 0;
    int          nfail = 0;
    logic [39:0] r_paddr;
    logic [2:0]  r_cause;
    logic        r_w, r_u;

    function automatic logic [63:0] ent(input logic [39:0] nxt, input logic [2:0] fl,
                                        input logic xd);
        return {xd, 23'b0, nxt[39:12], 9'b0, fl};
    endfunction

    function automatic logic [63:0] mkva(input int i4, input int i3, input int i2,
                                         input int i1, input int off);
        logic [63:0] v;
        v = {16'b0, 9'(i4), 9'(i3), 9'(i2), 9'(i1), 12'(off)};
        if (v[47]) v[63:48] = '1;
        return v;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: two-cycle read latency, optional request stall
    initial begin
        logic [63:0] a_q;
        int lat;
        lat = 0;
        a_q = '0;
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) mem_rsp_valid = 1'b0;
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pmem.exists(a_q) ? pmem[a_q] : 64'h0;
                end
            end
            mem_req_ready = (stall_cnt == 0);
            if (stall_cnt > 0) stall_cnt--;
            if (mem_req_valid && mem_req_ready) begin
                a_q = mem_req_addr;
                if (nreads < 8) rd_log[nreads] = mem_req_addr;
                nreads++;
                lat = 2;
            end
        end
    end

    task automatic launch(input logic [63:0] va, input logic w, input logic u,
                          input logic x, input logic nx);
        nreads = 0;
        @(negedge clk);
        req_vaddr = va; req_write = w; req_user = u; req_fetch = x;
        nx_enable = nx; req_valid = 1'b1;
        for (int t = 0; t < 100 && !req_ready; t++) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic await_rsp();
        int t;
        t = 0;
        while (!rsp_valid && t < 300) begin @(negedge clk); t++; end
        if (!rsp_valid) check("R9 response timeout", 0, 1);
        r_paddr = rsp_paddr; r_cause = rsp_cause; r_w = rsp_writable; r_u = rsp_user;
    endtask

    task automatic take_rsp();
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic translate(input logic [63:0] va, input logic w, input logic u,
                             input logic x, input logic nx);
        launch(va, w, u, x, nx);
        await_rsp();
        take_rsp();
    endtask

    task automatic t_reset();
        check("R11 req_ready", req_ready, 1);
        check("R11 rsp_valid", rsp_valid, 0);
        check("R11 mem_req_valid", mem_req_valid, 0);
    endtask

    task automatic t_basic();
        translate(mkva(1, 2, 3, 4, 12'hABC), 1, 1, 0, 0);
        check("R3 cause", r_cause, 0);
        check("R3 paddr", r_paddr, 40'h12_3456_7ABC);
        check("R6 perms", {r_w, r_u}, 2'b11);
        check("R2 reads", nreads, 4);
        check("R2 read0", rd_log[0], 64'h1000 + 1*8);
        check("R2 read1", rd_log[1], 64'h2000 + 2*8);
        check("R2 read2", rd_log[2], 64'h3000 + 3*8);
        check("R2 read3", rd_log[3], 64'h4000 + 4*8);
    endtask

    task automatic t_canon();
        translate(64'h0001_0000_0000_0000, 0, 0, 0, 0);
        check("R1 cause", r_cause, 1);
        check("R1 no reads", nreads, 0);
        check("R12 paddr zero", r_paddr, 0);
        translate(64'h7FFF_8000_0000_0000, 0, 0, 0, 0);
        check("R1 cause upper", r_cause, 1);
        translate(mkva(256, 2, 3, 4, 12'h010), 0, 0, 0, 0);
        check("R1 negative half accepted", r_cause, 0);
        check("R3 negative half paddr", r_paddr, 40'h12_3456_7010);
        check("R2 negative half read0", rd_log[0], 64'h1000 + 256*8);
    endtask

    task automatic t_absent_rsvd();
        translate(mkva(1, 2, 5, 0, 0), 0, 0, 0, 0);
        check("R4 cause", r_cause, 2);
        check("R4 reads", nreads, 3);
        check("R12 perms zero", {r_w, r_u}, 2'b00);
        translate(mkva(1, 7, 0, 0, 0), 0, 0, 0, 0);
        check("R5 cause", r_cause, 3);
        check("R5 reads", nreads, 2);
    endtask

    task automatic t_protect();
        translate(mkva(1, 9, 1, 2, 12'h123), 1, 0, 0, 0);
        check("R6 write denied", r_cause, 4);
        translate(mkva(1, 9, 1, 2, 12'h123), 0, 1, 0, 0);
        check("R6 user denied", r_cause, 4);
        translate(mkva(1, 9, 1, 2, 12'h123), 0, 0, 0, 0);
        check("R6 read allowed", r_cause, 0);
        check("R6 read paddr", r_paddr, 40'hAB_CDE0_0123);
        check("R6 combined perms", {r_w, r_u}, 2'b00);
    endtask

    task automatic t_xd();
        translate(mkva(1, 10, 0, 0, 12'h7FF), 0, 0, 1, 1);
        check("R7 fetch faults", r_cause, 5);
        check("R7 leaf reached", nreads, 4);
        translate(mkva(1, 10, 0, 0, 12'h7FF), 0, 0, 1, 0);
        check("R7 nx off ignored", r_cause, 0);
        check("R7 nx off paddr", r_paddr, 40'h55_0000_07FF);
        translate(mkva(1, 10, 0, 0, 12'h7FF), 1, 1, 0, 1);
        check("R7 data read ignored", r_cause, 0);
        check("R7 data perms", {r_w, r_u}, 2'b11);
    endtask

    task automatic t_priority();
        translate(mkva(1, 11, 0, 0, 0), 0, 0, 0, 0);
        check("R8 absent beats reserved", r_cause, 2);
        check("R8 absent reads", nreads, 2);
        translate(mkva(1, 9, 3, 0, 0), 1, 0, 1, 1);
        check("R8 xd beats protection", r_cause, 5);
        translate(mkva(1, 9, 3, 0, 0), 1, 0, 0, 1);
        check("R8 protection alone", r_cause, 4);
    endtask

    task automatic t_hold();
        int rd0;
        launch(mkva(1, 2, 3, 4, 12'h001), 0, 0, 0, 0);
        await_rsp();
        rd0 = nreads;
        req_vaddr = 64'h0001_0000_0000_0000;
        req_valid = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R9 held valid", rsp_valid, 1);
            check("R9 held paddr", rsp_paddr, 40'h12_3456_7001);
            check("R9 not accepted", req_ready, 0);
        end
        req_valid = 1'b0;
        check("R9 no new reads", nreads, rd0);
        take_rsp();
        check("R9 idle after take", req_ready, 1);
    endtask

    task automatic t_stall();
        stall_cnt = 5;
        translate(mkva(1, 2, 3, 4, 12'h3C0), 0, 0, 0, 0);
        check("R10 stalled paddr", r_paddr, 40'h12_3456_73C0);
        check("R10 stalled reads", nreads, 4);
        check("R10 stalled read3", rd_log[3], 64'h4000 + 4*8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        pmem[64'h1000 + 1*8]   = ent(40'h2000, 3'b111, 0);
        pmem[64'h1000 + 256*8] = ent(40'h2000, 3'b111, 0);
        pmem[64'h2000 + 2*8]   = ent(40'h3000, 3'b111, 0);
        pmem[64'h3000 + 3*8]   = ent(40'h4000, 3'b111, 0);
        pmem[64'h4000 + 4*8]   = ent(40'h12_3456_7000, 3'b111, 0);
        pmem[64'h2000 + 7*8]   = ent(40'h5000, 3'b111, 0) | (64'h1 << 40);
        pmem[64'h2000 + 9*8]   = ent(40'h6000, 3'b111, 0);
        pmem[64'h6000 + 1*8]   = ent(40'h7000, 3'b101, 0);
        pmem[64'h7000 + 2*8]   = ent(40'hAB_CDE0_0000, 3'b011, 0);
        pmem[64'h6000 + 3*8]   = ent(40'hA000, 3'b101, 0);
        pmem[64'hA000]         = ent(40'h66_0000_0000, 3'b111, 1);
        pmem[64'h2000 + 10*8]  = ent(40'h8000, 3'b111, 0);
        pmem[64'h8000]         = ent(40'h9000, 3'b111, 1);
        pmem[64'h9000]         = ent(40'h55_0000_0000, 3'b111, 0);
        pmem[64'h2000 + 11*8]  = 64'h1 << 45;

        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_canon();
        t_absent_rsvd();
        t_protect();
        t_xd();
        t_priority();
        t_hold();
        t_stall();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule